// File: doc/BRIEF.md
# DMA Bus Steering Glue

This block sits between a byte-wide DMA engine, a serial link controller and a processor bus. When the DMA engine raises a request, the block bids for the processor bus. Once the processor hands the bus over, it latches a DMA-active state that acknowledges the grant. It holds that state until the transfer strobe has finished, so the state lasts longer than the request itself.

While DMA-active is set, the block does three things:
- It inverts the read/write line toward the link controller. A memory read becomes a peripheral write, which is transmit, and a memory write becomes a peripheral read, which is receive.
- It forces the controller's register-select lines to the transmit-continue code. On the last transmit byte it switches them to the frame-terminate code.
- It drives the system address strobe and lower data strobe, and times the memory chip select. On transmit the select is early; on receive it is timed to the transfer strobe.

All control inputs are active-low and the state is sampled on the rising clock edge.

Top module: `dma_bus_steer`

## Requirements
- R1: After reset `dma_on` is 0 and `bgack_n` is 1. Reset also clears an active DMA state.
- R2: When not active, `br_n` is 0 exactly while `dreq_n` is 0. When active, `br_n` is 1.
- R3: A clock edge that sees `dreq_n`=0 and `bg_n`=0 while not active sets `dma_on` to 1 and `bgack_n` to 0. A request without grant never sets it.
- R4: While active, `dma_on` stays 1 on any edge where `dreq_n` or `xstb_n` is 0. It clears on the first edge where both are 1.
- R5: `per_rw` equals `sys_rw` when not active and equals its inverse when active (1 = read).
- R6: When not active, `reg_sel[0]` = `addr_rs[0]` (address bit 1) and `reg_sel[1]` = `addr_rs[1]` (address bit 2).
- R7: When active, `reg_sel` is 2'b10 (select 1 high, select 0 low). The exception is transmit (`sys_rw`=1) with `dend_n`=0, where it is 2'b11.
- R8: Active transmit (`sys_rw`=1): `mem_cs_n` is 0 whenever `addr_top` equals the memory region 3'b101 (top bit first), independent of `as_n` and `xstb_n`.
- R9: Active receive (`sys_rw`=0): `mem_cs_n` is 0 only while the region matches and `xstb_n` is 0.
- R10: When not active, `mem_cs_n` is 0 only while the region matches and `as_n` is 0.
- R11: `bus_as_n` and `bus_lds_n` are 0 while active and 1 (released) otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| dreq_n | input | 1 | DMA request from the DMA engine |
| bg_n | input | 1 | bus grant from the processor |
| xstb_n | input | 1 | transfer strobe |
| dend_n | input | 1 | end-of-block from the DMA engine |
| sys_rw | input | 1 | system read/write, 1 = read |
| as_n | input | 1 | processor address strobe |
| addr_top | input | 3 | top three system address bits |
| addr_rs | input | 2 | address bits 2 and 1 |
| br_n | output | 1 | bus request to processor |
| bgack_n | output | 1 | bus grant acknowledge |
| dma_on | output | 1 | DMA-active state |
| per_rw | output | 1 | read/write toward link controller |
| reg_sel | output | 2 | link controller register selects |
| mem_cs_n | output | 1 | memory chip select |
| bus_as_n | output | 1 | address strobe driven during DMA |
| bus_lds_n | output | 1 | lower data strobe driven during DMA |

## Verification
The steering outputs are swept over every combination of read/write, address selects, region bits, end-of-block, strobe and address strobe. This is done once in the idle state and once in the active state. The two sweeps separate the pass-through paths from the inverted and forced ones. They also separate the early transmit select from the strobe-timed receive select, and the end-of-block code from the continue code.

Sequence tests cover the set/clear handshake:
- a request held without grant;
- a grant that releases the request;
- the request dropping while the strobe is still low;
- the final release;
- reset during DMA.

These tests show that the active state outlasts the request and clears on exactly the right edge.

// File: rtl/dma_bus_steer.sv
module dma_bus_steer #(
  parameter int             TOPW   = 3,
  parameter logic [TOPW-1:0] REGION = 3'b101
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dreq_n,
  input  logic            bg_n,
  input  logic            xstb_n,
  input  logic            dend_n,
  input  logic            sys_rw,
  input  logic            as_n,
  input  logic [TOPW-1:0] addr_top,
  input  logic [1:0]      addr_rs,
  output logic            br_n,
  output logic            bgack_n,
  output logic            dma_on,
  output logic            per_rw,
  output logic [1:0]      reg_sel,
  output logic            mem_cs_n,
  output logic            bus_as_n,
  output logic            bus_lds_n
);

  logic act;
  logic hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      act <= 1'b0;
    else if (!act && !dreq_n && !bg_n)
      act <= 1'b1;
    else if (act && dreq_n && xstb_n)
      act <= 1'b0;
  end

  assign hit       = (addr_top == REGION);
  assign dma_on    = act;
  assign bgack_n   = ~act;
  assign br_n      = act | dreq_n;
  assign per_rw    = sys_rw ^ act;
  assign bus_as_n  = ~act;
  assign bus_lds_n = ~act;

  always_comb begin
    if (!act)
      reg_sel = addr_rs;
    else if (sys_rw && !dend_n)
      reg_sel = 2'b11;
    else
      reg_sel = 2'b10;
  end

  always_comb begin
    if (!act)
      mem_cs_n = ~(hit & ~as_n);
    else if (sys_rw)
      mem_cs_n = ~hit;
    else
      mem_cs_n = ~(hit & ~xstb_n);
  end

  // R2
  req_ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!br_n && !bgack_n));

  // R3
  set_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_on) |-> ($past(!bg_n) && $past(!dreq_n)));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_on && (!dreq_n || !xstb_n)) |=> dma_on);

  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_on && dreq_n && xstb_n) |=> !dma_on);

  // R5
  rw_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_on |-> (per_rw != sys_rw));

  // R9
  rx_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_on && !sys_rw && xstb_n) |-> mem_cs_n);

  // R11
  strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as_n == bus_lds_n) && (bus_as_n == bgack_n));

endmodule

// File: tb/dma_bus_steer_test.sv
module dma_bus_steer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dreq_n = 1'b1, bg_n = 1'b1, xstb_n = 1'b1, dend_n = 1'b1;
  logic sys_rw = 1'b1, as_n = 1'b1;
  logic [2:0] addr_top = 3'b000;
  logic [1:0] addr_rs = 2'b00;
  logic br_n, bgack_n, dma_on, per_rw, mem_cs_n, bus_as_n, bus_lds_n;
  logic [1:0] reg_sel;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  dma_bus_steer uut (
    .clk(clk), .rst_n(rst_n), .dreq_n(dreq_n), .bg_n(bg_n), .xstb_n(xstb_n),
    .dend_n(dend_n), .sys_rw(sys_rw), .as_n(as_n), .addr_top(addr_top),
    .addr_rs(addr_rs), .br_n(br_n), .bgack_n(bgack_n), .dma_on(dma_on),
    .per_rw(per_rw), .reg_sel(reg_sel), .mem_cs_n(mem_cs_n),
    .bus_as_n(bus_as_n), .bus_lds_n(bus_lds_n)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic sweep(input logic a);
    for (int v = 0; v < 512; v++) begin
      @(negedge clk);
      sys_rw   = v[0];
      addr_rs  = v[2:1];
      addr_top = v[5:3];
      dend_n   = v[6];
      xstb_n   = v[7];
      as_n     = v[8];
      #2;
      begin
        logic hit;
        logic [1:0] ers;
        logic ecs;
        hit = (v[5:3] == 3'd5);
        if (!a) begin
          ers = v[2:1];
          ecs = !(hit && !v[8]);
        end else begin
          ers = (v[0] && !v[6]) ? 2'd3 : 2'd2;
          ecs = v[0] ? !hit : !(hit && !v[7]);
        end
        check(a ? "R7" : "R6", {6'd0, reg_sel}, {6'd0, ers});
        check(a ? (v[0] ? "R8" : "R9") : "R10", {7'd0, mem_cs_n}, {7'd0, ecs});
        check("R5", {7'd0, per_rw}, {7'd0, v[0] ^ a});
        check("R11", {6'd0, bus_as_n, bus_lds_n}, a ? 8'd0 : 8'd3);
      end
    end
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1", {6'd0, dma_on, bgack_n}, 8'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {6'd0, dma_on, bgack_n}, 8'd1);
    check("R2", {7'd0, br_n}, 8'd1);

    sweep(1'b0);

    // request without grant: never sets
    @(negedge clk); dreq_n = 1'b0; xstb_n = 1'b1;
    #2 check("R2", {7'd0, br_n}, 8'd0);
    repeat (4) @(negedge clk);
    check("R3", {7'd0, dma_on}, 8'd0);

    // grant: set on next edge
    bg_n = 1'b0;
    @(negedge clk);
    check("R3", {6'd0, dma_on, bgack_n}, 8'd2);
    check("R2", {7'd0, br_n}, 8'd1);
    bg_n = 1'b1;

    sweep(1'b1);

    // request drops, strobe still low: hold
    @(negedge clk); dreq_n = 1'b1; xstb_n = 1'b0;
    @(negedge clk);
    check("R4", {7'd0, dma_on}, 8'd1);
    @(negedge clk);
    check("R4", {7'd0, dma_on}, 8'd1);
    xstb_n = 1'b1;
    @(negedge clk);
    check("R4", {6'd0, dma_on, bgack_n}, 8'd1);
    check("R2", {7'd0, br_n}, 8'd1);

    // strobe high, request low: hold
    dreq_n = 1'b0; bg_n = 1'b0;
    @(negedge clk);
    check("R3", {7'd0, dma_on}, 8'd1);
    bg_n = 1'b1;
    @(negedge clk);
    check("R4", {7'd0, dma_on}, 8'd1);

    // reset during DMA
    rst_n = 1'b0;
    #2 check("R1", {6'd0, dma_on, bgack_n}, 8'd1);
    dreq_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {7'd0, dma_on}, 8'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule